// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

Two single-word bypass registers let two ports on unrelated clocks pass one 36-bit word each way without going through a queue. Port A deposits into mailbox 1 and collects from mailbox 2. Port B deposits into mailbox 2 and collects from mailbox 1. Each mailbox has an active-low full flag in the writer's clock domain. A write sets the flag. A read by the opposite port clears it. While the flag is LOW, that mailbox accepts no new writes.

The set and clear events cross between the clock domains as toggles. Each direction goes through a two-flop synchronizer. The writer's full flag returns HIGH only after the reader's clear has travelled back to the writer. Each reader also has a mail-waiting flag in its own clock domain, so it knows when a word is ready to collect.

Port A selects the mailbox with a dedicated select input. Port B selects it when its 2-bit bus-size code equals the mailbox code, binary 11. On both ports a read multiplexer returns either the mailbox contents or the word on the port's FIFO-data input.

Top module: `dual_clk_mailbox`

## Requirements
- R1: A port acts on a rising edge of its own clock only if its chip select (active low) is LOW and its enable is HIGH. Write select HIGH means write and LOW means read. An edge that fails either qualifier changes no flag and no register.
- R2: A qualified port A write with the mailbox select HIGH loads mailbox 1 and drives `mb1_full_no` LOW from that edge on. The same write with the mailbox select LOW leaves `mb1_full_no` HIGH.
- R3: While a mailbox's full flag is LOW, writes to that mailbox are ignored: the stored word is unchanged and the flag stays LOW.
- R4: A qualified port B read with `b_size_i` = 2'b11, made while `mb1_ready_o` is HIGH, drops `mb1_ready_o` after that edge. `mb1_full_no` then returns HIGH within four port A rising edges. A port B read with any other size code clears nothing.
- R5: A qualified port B write with `b_size_i` = 2'b11 loads mailbox 2 and drives `mb2_full_no` LOW. A qualified port A read with the mailbox select HIGH, made while `mb2_ready_o` is HIGH, clears mailbox 2 in the same way as R4.
- R6: `a_data_o` shows mailbox 2 when `a_mb_i` is HIGH and `a_fifo_data_i` otherwise. `b_data_o` shows mailbox 1 when `b_size_i` = 2'b11 and `b_fifo_data_i` otherwise.
- R7: The reader's mail-waiting flag rises no later than the third rising edge of the reader's clock after an accepted write. It is never HIGH while the writer's full flag reads empty.
- R8: While `rst_ni` is LOW, both full flags are HIGH and both mail-waiting flags are LOW.
- R9: A mailbox read made while no mail is waiting has no effect. In particular, it does not clear a word that is written afterwards.
- R10: Across a stream of writes and reads on unrelated clocks, every accepted word is delivered exactly once and in order, and no blocked word ever appears.
- R11: Reads do not alter the stored word. After a clear, the mailbox still shows the last accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk_i | input | 1 | Port A clock |
| b_clk_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_cs_ni | input | 1 | Port A chip select, active low |
| a_en_i | input | 1 | Port A enable |
| a_wr_i | input | 1 | Port A write (1) / read (0) |
| a_mb_i | input | 1 | Port A mailbox select |
| a_data_i | input | 36 | Port A write data |
| a_fifo_data_i | input | 36 | FIFO word offered on port A reads |
| a_data_o | output | 36 | Port A read data |
| b_cs_ni | input | 1 | Port B chip select, active low |
| b_en_i | input | 1 | Port B enable |
| b_wr_i | input | 1 | Port B write (1) / read (0) |
| b_size_i | input | 2 | Port B bus-size code; 2'b11 selects the mailbox |
| b_data_i | input | 36 | Port B write data |
| b_fifo_data_i | input | 36 | FIFO word offered on port B reads |
| b_data_o | output | 36 | Port B read data |
| mb1_full_no | output | 1 | Mailbox 1 full, active low, port A domain |
| mb1_ready_o | output | 1 | Mailbox 1 mail waiting, port B domain |
| mb2_full_no | output | 1 | Mailbox 2 full, active low, port B domain |
| mb2_ready_o | output | 1 | Mailbox 2 mail waiting, port A domain |

## Verification
If a toggle falls out of step, the fault shows at the ports in one of two ways. A full flag can stay LOW forever, which stops the stream until the watchdog ends the run. Or a mail-waiting flag can rise with no write behind it, so the reader collects a word it was never sent. A lost or repeated word shows on the first read after the fault, as a scoreboard mismatch or an empty queue. A write that slips past a full flag overwrites the stored word before the reader collects it, so the reader gets the wrong word. A clear taken from a read with nothing waiting lets a later write be lost. That shows within a handful of port A edges, as a full flag that goes HIGH with no read behind it.

// File: rtl/mailbox_pkg.sv
package mailbox_pkg;
  localparam int          MB_WIDTH     = 36;
  localparam int          MB_SYNC      = 2;
  localparam logic [1:0]  MB_SIZE_CODE = 2'b11;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/mbox_port_ctl.sv
module mbox_port_ctl (
  input  logic cs_ni,
  input  logic en_i,
  input  logic wr_i,
  input  logic sel_i,
  output logic wr_req_o,
  output logic rd_req_o
);
  logic act;

  assign act      = !cs_ni && en_i && sel_i;
  assign wr_req_o = act && wr_i;
  assign rd_req_o = act && !wr_i;
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel #(
  parameter int W      = 36,
  parameter int STAGES = 2
) (
  input  logic         w_clk_i,
  input  logic         r_clk_i,
  input  logic         rst_ni,
  input  logic         w_req_i,
  input  logic [W-1:0] w_data_i,
  input  logic         r_req_i,
  output logic [W-1:0] mail_o,
  output logic         full_no,
  output logic         ready_o
);
  logic         w_tog_q, w_ack_s, w_full, w_take;
  logic         r_tog_s, r_ack_q;
  logic [W-1:0] mail_q;

  // writer domain
  assign w_full = w_tog_q ^ w_ack_s;
  assign w_take = w_req_i && !w_full;

  always_ff @(posedge w_clk_i or negedge rst_ni) begin
    if (!rst_ni)     w_tog_q <= 1'b0;
    else if (w_take) w_tog_q <= ~w_tog_q;
  end

  // data is held stable until the ack returns, so it needs no reset
  always_ff @(posedge w_clk_i) begin
    if (w_take) mail_q <= w_data_i;
  end

  mbox_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk_i(w_clk_i), .rst_ni(rst_ni), .d_i(r_ack_q), .q_o(w_ack_s)
  );

  // reader domain
  mbox_sync #(.STAGES(STAGES)) u_tog_sync (
    .clk_i(r_clk_i), .rst_ni(rst_ni), .d_i(w_tog_q), .q_o(r_tog_s)
  );

  assign ready_o = r_tog_s ^ r_ack_q;

  always_ff @(posedge r_clk_i or negedge rst_ni) begin
    if (!rst_ni)                   r_ack_q <= 1'b0;
    else if (r_req_i && ready_o)   r_ack_q <= ~r_ack_q;
  end

  assign full_no = !w_full;
  assign mail_o  = mail_q;
endmodule

// File: rtl/dual_clk_mailbox.sv
module dual_clk_mailbox
  import mailbox_pkg::*;
#(
  parameter int W      = MB_WIDTH,
  parameter int STAGES = MB_SYNC
) (
  input  logic         a_clk_i,
  input  logic         b_clk_i,
  input  logic         rst_ni,
  input  logic         a_cs_ni,
  input  logic         a_en_i,
  input  logic         a_wr_i,
  input  logic         a_mb_i,
  input  logic [W-1:0] a_data_i,
  input  logic [W-1:0] a_fifo_data_i,
  output logic [W-1:0] a_data_o,
  input  logic         b_cs_ni,
  input  logic         b_en_i,
  input  logic         b_wr_i,
  input  logic [1:0]   b_size_i,
  input  logic [W-1:0] b_data_i,
  input  logic [W-1:0] b_fifo_data_i,
  output logic [W-1:0] b_data_o,
  output logic         mb1_full_no,
  output logic         mb1_ready_o,
  output logic         mb2_full_no,
  output logic         mb2_ready_o
);
  localparam logic [1:0] B_MB_CODE = MB_SIZE_CODE;

  logic         a_wr_req, a_rd_req, b_wr_req, b_rd_req, b_sel;
  logic [W-1:0] mail1_w, mail2_w;

  assign b_sel = (b_size_i == B_MB_CODE);

  mbox_port_ctl u_a_ctl (
    .cs_ni(a_cs_ni), .en_i(a_en_i), .wr_i(a_wr_i), .sel_i(a_mb_i),
    .wr_req_o(a_wr_req), .rd_req_o(a_rd_req)
  );

  mbox_port_ctl u_b_ctl (
    .cs_ni(b_cs_ni), .en_i(b_en_i), .wr_i(b_wr_i), .sel_i(b_sel),
    .wr_req_o(b_wr_req), .rd_req_o(b_rd_req)
  );

  // mailbox 1: A -> B
  mbox_channel #(.W(W), .STAGES(STAGES)) u_ch1 (
    .w_clk_i(a_clk_i), .r_clk_i(b_clk_i), .rst_ni(rst_ni),
    .w_req_i(a_wr_req), .w_data_i(a_data_i), .r_req_i(b_rd_req),
    .mail_o(mail1_w), .full_no(mb1_full_no), .ready_o(mb1_ready_o)
  );

  // mailbox 2: B -> A
  mbox_channel #(.W(W), .STAGES(STAGES)) u_ch2 (
    .w_clk_i(b_clk_i), .r_clk_i(a_clk_i), .rst_ni(rst_ni),
    .w_req_i(b_wr_req), .w_data_i(b_data_i), .r_req_i(a_rd_req),
    .mail_o(mail2_w), .full_no(mb2_full_no), .ready_o(mb2_ready_o)
  );

  assign a_data_o = a_mb_i ? mail2_w : a_fifo_data_i;
  assign b_data_o = b_sel  ? mail1_w : b_fifo_data_i;
endmodule

// File: rtl/mailbox_chk.sv
module mailbox_chk #(
  parameter int W = 36
) (
  input logic         a_clk_i,
  input logic         b_clk_i,
  input logic         rst_ni,
  input logic         a_cs_ni,
  input logic         a_en_i,
  input logic         a_wr_i,
  input logic         a_mb_i,
  input logic         b_cs_ni,
  input logic         b_en_i,
  input logic         b_wr_i,
  input logic [1:0]   b_size_i,
  input logic [W-1:0] mail1_i,
  input logic         mb1_full_no,
  input logic         mb1_ready_o,
  input logic         mb2_full_no,
  input logic         mb2_ready_o
);
  logic a_wr_mb, b_wr_mb, b_rd_mb;

  assign a_wr_mb = !a_cs_ni && a_en_i && a_wr_i && a_mb_i;
  assign b_wr_mb = !b_cs_ni && b_en_i && b_wr_i && (b_size_i == 2'b11);
  assign b_rd_mb = !b_cs_ni && b_en_i && !b_wr_i && (b_size_i == 2'b11);

  // R8
  reset_flags_chk: assert property (@(posedge a_clk_i)
    !rst_ni |-> (mb1_full_no && mb2_full_no && !mb2_ready_o));

  // R2
  a_write_sets_full_chk: assert property (@(posedge a_clk_i) disable iff (!rst_ni)
    (mb1_full_no && a_wr_mb) |=> !mb1_full_no);

  // R3
  blocked_write_keeps_data_chk: assert property (@(posedge a_clk_i) disable iff (!rst_ni)
    (!mb1_full_no && a_wr_mb) |=> $stable(mail1_i));

  // R4
  b_read_clears_ready_chk: assert property (@(posedge b_clk_i) disable iff (!rst_ni)
    (mb1_ready_o && b_rd_mb) |=> !mb1_ready_o);

  // R5
  b_write_sets_full_chk: assert property (@(posedge b_clk_i) disable iff (!rst_ni)
    (mb2_full_no && b_wr_mb) |=> !mb2_full_no);

  // R7
  ready_implies_full_chk: assert property (@(posedge b_clk_i) disable iff (!rst_ni)
    mb1_ready_o |-> !mb1_full_no);
endmodule

bind dual_clk_mailbox mailbox_chk #(.W(W)) u_chk (
  .a_clk_i(a_clk_i), .b_clk_i(b_clk_i), .rst_ni(rst_ni),
  .a_cs_ni(a_cs_ni), .a_en_i(a_en_i), .a_wr_i(a_wr_i), .a_mb_i(a_mb_i),
  .b_cs_ni(b_cs_ni), .b_en_i(b_en_i), .b_wr_i(b_wr_i), .b_size_i(b_size_i),
  .mail1_i(mail1_w), .mb1_full_no(mb1_full_no), .mb1_ready_o(mb1_ready_o),
  .mb2_full_no(mb2_full_no), .mb2_ready_o(mb2_ready_o)
);

// File: tb/dual_clk_mailbox_test.sv
module dual_clk_mailbox_test;
  localparam int W = 36;
  localparam int NSTREAM = 40;

  logic a_clk = 0, b_clk = 0, rst_n = 0;
  logic a_cs_n = 1, a_en = 0, a_wr = 0, a_mb = 0;
  logic b_cs_n = 1, b_en = 0, b_wr = 0;
  logic [1:0] b_size = 2'b00;
  logic [W-1:0] a_din = '0, b_din = '0;
  logic [W-1:0] a_fifo = 36'hA_AAAA_0001, b_fifo = 36'hB_BBBB_0002;
  logic [W-1:0] a_dout, b_dout;
  logic mb1_full_n, mb1_rdy, mb2_full_n, mb2_rdy;

  int checks = 0, errors = 0, got = 0;
  logic [W-1:0] exp_q[$];

  always #10 a_clk = ~a_clk;   // 50 MHz
  always #13.7 b_clk = ~b_clk; // unrelated

  dual_clk_mailbox uut (
    .a_clk_i(a_clk), .b_clk_i(b_clk), .rst_ni(rst_n),
    .a_cs_ni(a_cs_n), .a_en_i(a_en), .a_wr_i(a_wr), .a_mb_i(a_mb),
    .a_data_i(a_din), .a_fifo_data_i(a_fifo), .a_data_o(a_dout),
    .b_cs_ni(b_cs_n), .b_en_i(b_en), .b_wr_i(b_wr), .b_size_i(b_size),
    .b_data_i(b_din), .b_fifo_data_i(b_fifo), .b_data_o(b_dout),
    .mb1_full_no(mb1_full_n), .mb1_ready_o(mb1_rdy),
    .mb2_full_no(mb2_full_n), .mb2_ready_o(mb2_rdy)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic a_op(input logic cs_n, input logic en, input logic wr,
                      input logic mb, input logic [W-1:0] d);
    @(negedge a_clk);
    a_cs_n = cs_n; a_en = en; a_wr = wr; a_mb = mb; a_din = d;
    @(posedge a_clk);
    @(negedge a_clk);
    a_cs_n = 1; a_en = 0; a_wr = 0; a_mb = 0;
  endtask

  task automatic b_op(input logic wr, input logic [1:0] sz, input logic [W-1:0] d);
    @(negedge b_clk);
    b_cs_n = 0; b_en = 1; b_wr = wr; b_size = sz; b_din = d;
    @(posedge b_clk);
    @(negedge b_clk);
    b_cs_n = 1; b_en = 0; b_wr = 0; b_size = 2'b00;
  endtask

  // returns number of reader edges waited, 99 if never
  task automatic wait_b_rdy(output int n);
    n = 99;
    for (int i = 1; i <= 6; i++) begin
      @(negedge b_clk);
      if (mb1_rdy) begin n = i; break; end
    end
  endtask

  task automatic wait_a_full_high(output int n);
    n = 99;
    for (int i = 1; i <= 6; i++) begin
      @(negedge a_clk);
      if (mb1_full_n) begin n = i; break; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge a_clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int n;
    // R8 reset state
    repeat (3) @(negedge a_clk);
    chk("R8 mb1_full_no", W'(mb1_full_n), W'(1));
    chk("R8 mb2_full_no", W'(mb2_full_n), W'(1));
    chk("R8 ready", W'({mb1_rdy, mb2_rdy}), W'(0));
    @(negedge a_clk); rst_n = 1;
    repeat (3) @(negedge b_clk);

    // R1 unqualified edges
    a_op(1, 1, 1, 1, 36'h0_DEAD_0001);
    chk("R1 cs high", W'(mb1_full_n), W'(1));
    a_op(0, 0, 1, 1, 36'h0_DEAD_0002);
    chk("R1 en low", W'(mb1_full_n), W'(1));
    // R2 select low is not a mailbox write
    a_op(0, 1, 1, 0, 36'h0_DEAD_0003);
    chk("R2 select low", W'(mb1_full_n), W'(1));

    // R2 mailbox write
    a_op(0, 1, 1, 1, 36'h1_2345_6789);
    chk("R2 full after write", W'(mb1_full_n), W'(0));
    // R3 blocked write
    a_op(0, 1, 1, 1, 36'hF_0000_BAD0);
    chk("R3 stays full", W'(mb1_full_n), W'(0));

    // R7 ready arrives in time
    wait_b_rdy(n);
    chk("R7 ready latency ok", W'(n <= 3), W'(1));

    // R6 + R3 B-side mux
    @(negedge b_clk); b_size = 2'b11; #1;
    chk("R3/R6 mailbox word", b_dout, 36'h1_2345_6789);
    b_size = 2'b01; #1;
    chk("R6 fifo word on B", b_dout, b_fifo);
    b_size = 2'b00;

    // R4 non-mailbox read clears nothing
    b_op(0, 2'b10, '0);
    chk("R4 other size keeps ready", W'(mb1_rdy), W'(1));
    chk("R4 other size keeps full", W'(mb1_full_n), W'(0));

    // R4 mailbox read
    b_op(0, 2'b11, '0);
    chk("R4 ready drops", W'(mb1_rdy), W'(0));
    wait_a_full_high(n);
    chk("R4 full returns", W'(n <= 4), W'(1));

    // R11 read left contents
    @(negedge b_clk); b_size = 2'b11; #1;
    chk("R11 contents kept", b_dout, 36'h1_2345_6789);
    b_size = 2'b00;

    // R9 read with nothing waiting
    b_op(0, 2'b11, '0);
    chk("R9 ready stays low", W'(mb1_rdy), W'(0));
    a_op(0, 1, 1, 1, 36'h3_3333_3333);
    repeat (8) @(negedge a_clk);
    chk("R9 later write not cleared", W'(mb1_full_n), W'(0));
    wait_b_rdy(n);
    @(negedge b_clk); b_size = 2'b11; #1;
    chk("R9 new word", b_dout, 36'h3_3333_3333);
    b_size = 2'b00;
    b_op(0, 2'b11, '0);
    wait_a_full_high(n);

    // R5 mailbox 2
    b_op(1, 2'b11, 36'h4_4444_0004);
    chk("R5 mb2 full", W'(mb2_full_n), W'(0));
    n = 99;
    for (int i = 1; i <= 6; i++) begin
      @(negedge a_clk);
      if (mb2_rdy) begin n = i; break; end
    end
    chk("R7 mb2 ready latency", W'(n <= 3), W'(1));
    a_mb = 1; #1;
    chk("R6 mailbox 2 on A", a_dout, 36'h4_4444_0004);
    a_mb = 0; #1;
    chk("R6 fifo word on A", a_dout, a_fifo);
    a_op(0, 1, 0, 1, '0);
    chk("R5 mb2 ready drops", W'(mb2_rdy), W'(0));
    n = 99;
    for (int i = 1; i <= 6; i++) begin
      @(negedge b_clk);
      if (mb2_full_n) begin n = i; break; end
    end
    chk("R5 mb2 full returns", W'(n <= 4), W'(1));

    // R10 stream scoreboard
    fork
      begin : driver
        for (int i = 0; i < NSTREAM; i++) begin
          logic done;
          done = 0;
          while (!done) begin
            @(negedge a_clk);
            done = mb1_full_n;
            a_cs_n = 0; a_en = 1; a_wr = 1; a_mb = 1;
            a_din = done ? W'(36'h5_0000_0000 + i) : W'(36'hE_EEEE_0000 + i);
            @(posedge a_clk);
            if (done) exp_q.push_back(36'h5_0000_0000 + i);
          end
        end
        @(negedge a_clk);
        a_cs_n = 1; a_en = 0; a_wr = 0; a_mb = 0;
      end
      begin : monitor
        while (got < NSTREAM) begin
          @(negedge b_clk);
          b_cs_n = 1; b_en = 0; b_size = 2'b00;
          if (mb1_rdy) begin
            b_cs_n = 0; b_en = 1; b_wr = 0; b_size = 2'b11; #1;
            if (exp_q.size() == 0) chk("R10 unexpected word", b_dout, 'x);
            else chk("R10 stream word", b_dout, exp_q.pop_front());
            got++;
          end
        end
        @(negedge b_clk);
        b_cs_n = 1; b_en = 0; b_size = 2'b00;
      end
    join
    repeat (10) @(negedge b_clk);
    chk("R10 no extra delivery", W'(mb1_rdy), W'(0));
    chk("R10 queue drained", W'(exp_q.size()), W'(0));
    summary();
  end
endmodule